// File: doc/BRIEF.md
# Two-Port Bidirectional Storage Transceiver

This block moves data between two shared buses, port A and port B, each `WIDTH` bits wide (18 by default). Each direction has its own storage element and its own three controls: an output enable, a flow-through (transparent) control and a strobe. A direction either passes data straight across, holds what it last saw, or loads a fresh word when its strobe falls. The stored word for A-to-B is driven onto the B pads, and the stored word for B-to-A is driven onto the A pads.

Inside a synchronous chip, every control and pad input is sampled on the system clock `clk`. A word that enters in one cycle appears on the far pads after that clock edge. The two output enables have opposite polarity. A disabled side releases its pads to high impedance, so another agent can drive them. Each pad is an `inout` net; the port's own input path reads that same net.

The pads carry level data with no handshake. There is no valid/ready pair, because nothing on the bus can push back, and the controls are plain level pins.

Top module: `bxc_transceiver`

## Requirements
- R1: After reset both stored words are zero. If a side is enabled with flow-through low and its strobe held low, its pads read zero.
- R2: When a direction's flow-through input `*_flow` is high at a `clk` edge, that direction stores the source pad value it sees at that edge. The enabled destination pads show the value after the edge.
- R3: When flow-through is low and the strobe shows no high-to-low change between two `clk` samples, the stored word does not change. This covers a strobe held high, held low, or rising.
- R4: When flow-through is low, a strobe sampled high at one `clk` edge and low at the next loads the source pad value present at that second edge.
- R5: A strobe that falls while flow-through is high causes no separate load. After flow-through drops, the word held is the last one passed through.
- R6: `ab_oe` is active high. When it is high, `b_pad` carries the A-to-B stored word. When it is low, the block releases `b_pad` and an external driver's value is seen there.
- R7: `ba_oe_n` is active low. When it is low, `a_pad` carries the B-to-A stored word. When it is high, the block releases `a_pad` and an external driver's value is seen there.
- R8: The two directions are independent. One direction can be transparent while the other loads on a strobe edge in the same cycle. When the block itself drives a source pad, that direction takes the value the block drives.
- R9: If the strobe is high when flow-through goes low, the word passed through is held. A later fall of the strobe then loads a new word, as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls and pads are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears both stored words |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_flow | input | 1 | A-to-B flow-through (transparent) control |
| ab_strobe | input | 1 | A-to-B load strobe; loads on a falling change |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_flow | input | 1 | B-to-A flow-through (transparent) control |
| ba_strobe | input | 1 | B-to-A load strobe; loads on a falling change |
| a_pad | inout | WIDTH | Port A bus: source for A-to-B, driven by B-to-A |
| b_pad | inout | WIDTH | Port B bus: source for B-to-A, driven by A-to-B |

## Verification
Two functions can fall in the same cycle. In one cycle a direction can be transparent while the other loads on a strobe edge. The loading direction may take its word from a pad that the block itself is driving.

The bench provokes this by enabling both sides. It then runs one direction in flow-through while the opposite strobe falls. The reference model resolves each source pad from the pre-edge word, either the block's own drive or the bench's drive. Both pads are compared after the edge against the values the model predicts.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
  // Why a direction's storage element updates in a given cycle.
  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_FLOW = 2'd1,
    CAP_EDGE = 2'd2
  } cap_e;
endpackage

// File: rtl/bxc_store.sv
module bxc_store
  import bxc_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flow,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic strobe_q;
  cap_e cap;

  always_comb begin
    if (flow)                  cap = CAP_FLOW;
    else if (strobe_q && !strobe) cap = CAP_EDGE;
    else                       cap = CAP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe;
      case (cap)
        CAP_FLOW, CAP_EDGE: q <= din;
        default:            q <= q;
      endcase
    end
  end

  // R2
  flow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow |=> q == $past(din));
  // R4
  edge_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && strobe_q && !strobe) |=> q == $past(din));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && !(strobe_q && !strobe)) |=> $stable(q));
endmodule

// File: rtl/bxc_pad_drive.sv
module bxc_pad_drive #(
  parameter int W       = 18,
  parameter bit ACT_LOW = 1'b0
) (
  input  logic         en_pin,
  input  logic [W-1:0] d,
  output logic         drv_en,
  output logic [W-1:0] drv
);
  generate
    if (ACT_LOW) begin : g_low
      assign drv_en = ~en_pin;
    end else begin : g_high
      assign drv_en = en_pin;
    end
  endgenerate
  assign drv = d;
endmodule

// File: rtl/bxc_transceiver.sv
module bxc_transceiver #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ab_oe,
  input  logic             ab_flow,
  input  logic             ab_strobe,
  input  logic             ba_oe_n,
  input  logic             ba_flow,
  input  logic             ba_strobe,
  inout  wire  [WIDTH-1:0] a_pad,
  inout  wire  [WIDTH-1:0] b_pad
);
  logic [WIDTH-1:0] q_ab, q_ba, a_drv, b_drv;
  logic             a_drv_en, b_drv_en;

  bxc_store #(.W(WIDTH)) u_st_ab (
    .clk(clk), .rst_n(rst_n), .flow(ab_flow), .strobe(ab_strobe),
    .din(a_pad), .q(q_ab));

  bxc_store #(.W(WIDTH)) u_st_ba (
    .clk(clk), .rst_n(rst_n), .flow(ba_flow), .strobe(ba_strobe),
    .din(b_pad), .q(q_ba));

  bxc_pad_drive #(.W(WIDTH), .ACT_LOW(1'b0)) u_drv_b (
    .en_pin(ab_oe), .d(q_ab), .drv_en(b_drv_en), .drv(b_drv));

  bxc_pad_drive #(.W(WIDTH), .ACT_LOW(1'b1)) u_drv_a (
    .en_pin(ba_oe_n), .d(q_ba), .drv_en(a_drv_en), .drv(a_drv));

  assign b_pad = b_drv_en ? b_drv : {WIDTH{1'bz}};
  assign a_pad = a_drv_en ? a_drv : {WIDTH{1'bz}};

  // R6
  b_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe |-> b_pad == q_ab);
  // R7
  a_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ba_oe_n |-> a_pad == q_ba);
endmodule

// File: tb/tb_bxc_transceiver.sv
module tb_bxc_transceiver;
  localparam int W = 18;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ab_oe = 1'b0, ab_flow = 1'b0, ab_strobe = 1'b0;
  logic ba_oe_n = 1'b1, ba_flow = 1'b0, ba_strobe = 1'b0;
  logic         tb_a_en = 1'b1, tb_b_en = 1'b1;
  logic [W-1:0] tb_a = '0, tb_b = '0;
  wire  [W-1:0] a_pad, b_pad;

  assign a_pad = tb_a_en ? tb_a : {W{1'bz}};
  assign b_pad = tb_b_en ? tb_b : {W{1'bz}};

  bxc_transceiver #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .ab_oe(ab_oe), .ab_flow(ab_flow), .ab_strobe(ab_strobe),
    .ba_oe_n(ba_oe_n), .ba_flow(ba_flow), .ba_strobe(ba_strobe),
    .a_pad(a_pad), .b_pad(b_pad));

  always #(CLK_PERIOD/2) clk = ~clk;

  item_t        sb[$];
  int           checks = 0, fails = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic         p_ab = 1'b0, p_ba = 1'b0;

  // Driver: applies one cycle of stimulus and predicts the pads after the edge.
  task automatic step(input logic aoe, input logic afl, input logic ast,
                      input logic boen, input logic bfl, input logic bst,
                      input logic [W-1:0] av, input logic [W-1:0] bv,
                      input string tag);
    logic [W-1:0] a_seen, b_seen;
    item_t it;
    @(negedge clk);
    ab_oe = aoe; ab_flow = afl; ab_strobe = ast;
    ba_oe_n = boen; ba_flow = bfl; ba_strobe = bst;
    tb_a_en = boen;  tb_a = av;
    tb_b_en = !aoe;  tb_b = bv;
    a_seen = boen ? av : m_ba;
    b_seen = !aoe ? bv : m_ab;
    if (afl || (p_ab && !ast)) m_ab = a_seen;
    if (bfl || (p_ba && !bst)) m_ba = b_seen;
    p_ab = ast; p_ba = bst;
    it.a = boen ? av : m_ba;
    it.b = !aoe ? bv : m_ab;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares right after each edge, away from it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (a_pad !== it.a) begin
          fails++;
          $display("FAIL %s a_pad actual %h expected %h", it.tag, a_pad, it.a);
        end
        checks++;
        if (b_pad !== it.b) begin
          fails++;
          $display("FAIL %s b_pad actual %h expected %h", it.tag, b_pad, it.b);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: both sides enabled, flow low, strobes low -> zero words
    step(1,0,0, 0,0,0, 18'h0, 18'h0, "R1");
    // R6: both disabled, bench words visible; A-to-B flows, B-to-A flows
    step(0,1,0, 1,1,0, 18'h00123, 18'h00456, "R6");
    // R6: A-to-B enabled, holding
    step(1,0,0, 1,0,0, 18'h00777, 18'h0, "R6");
    // R2: flow-through
    step(1,1,0, 1,0,0, 18'h2AAAA, 18'h0, "R2");
    step(1,1,0, 1,0,0, 18'h15555, 18'h0, "R2");
    // R3: hold with strobe low, rising, high
    step(1,0,0, 1,0,0, 18'h3FFFF, 18'h0, "R3");
    step(1,0,1, 1,0,0, 18'h11111, 18'h0, "R3");
    step(1,0,1, 1,0,0, 18'h12121, 18'h0, "R3");
    // R4: strobe falls -> load
    step(1,0,0, 1,0,0, 18'h22222, 18'h0, "R4");
    step(1,0,0, 1,0,0, 18'h23232, 18'h0, "R3");
    // R5: strobe falls during flow-through, no separate load
    step(1,1,1, 1,0,0, 18'h00F0F, 18'h0, "R5");
    step(1,1,0, 1,0,0, 18'h0F0F0, 18'h0, "R5");
    step(1,0,0, 1,0,0, 18'h33333, 18'h0, "R5");
    // R9: flow drops with strobe high, then fall loads
    step(1,1,1, 1,0,0, 18'h01234, 18'h0, "R9");
    step(1,0,1, 1,0,0, 18'h04321, 18'h0, "R9");
    step(1,0,0, 1,0,0, 18'h05678, 18'h0, "R9");
    // R7: B-to-A enabled (active low), flow from bench on B
    step(0,0,0, 0,1,0, 18'h0, 18'h1ABCD, "R7");
    step(0,0,0, 0,0,1, 18'h0, 18'h2BCDE, "R7");
    step(0,0,0, 0,0,0, 18'h0, 18'h3CDEF, "R7");
    step(0,0,0, 1,0,0, 18'h29876, 18'h0AAAA, "R7");
    // R8: both sides driven by the block; concurrent modes
    step(1,0,1, 0,1,0, 18'h0, 18'h0, "R8");
    step(1,0,0, 0,1,0, 18'h0, 18'h0, "R8");
    step(0,1,0, 0,0,1, 18'h0, 18'h31313, "R8");
    step(1,0,0, 0,0,0, 18'h0, 18'h0, "R8");
    step(1,0,0, 0,0,0, 18'h0, 18'h0, "R8");
    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule